// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial host read and write an on-chip byte-wide register space through a four-wire synchronous serial link. The four wires are a serial clock, host-to-slave data (MOSI), slave-to-host data (MISO) and an active-low select. Each access starts with a two-byte control word. The control word holds a direction flag, a 13-bit register address and a burst flag. One data byte follows it. Three static inputs set the idle clock level, the clock edge used for sampling and the bit order of the address and data fields.

The block runs entirely on a fast system clock. It oversamples the serial pins through synchronizers, so the serial clock half-period must be at least four system clock cycles. On the register side it pulses a write strobe carrying address and data, or a read strobe carrying an address. The read data is taken from `reg_rdata` in the cycle of the read strobe and is shifted out on MISO during the data byte.

While the select stays low, the host may chain accesses. After a non-burst access it sends a new control word. After a burst access it sends only further data bytes, which go to consecutive addresses. Raising the select always closes the current access.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `reg_wr`, `reg_rd`, `spi_miso` and `reg_addr` are all zero.
- R2: The control word is 16 bits, sent most significant first. Bit 15 is the direction (1 = read, 0 = write), bit 14 is ignored, bits 13:1 are the address and bit 0 is the burst flag. For a write, once the following data byte is complete, `reg_wr` pulses with that address and byte on `reg_addr`/`reg_wdata`.
- R3: For a read, `reg_rd` pulses with the address on `reg_addr` once the last control bit is sampled. The byte on `reg_rdata` in that cycle is driven on `spi_miso` during the data byte, one bit per serial clock, most significant bit first when `swap` is 0.
- R4: `cpol` gives the idle level of the serial clock. With `cpha` 0, data is sampled on the first edge away from idle and changed on the return edge. With `cpha` 1, data is changed on the first edge and sampled on the return edge. All four combinations work.
- R5: With `swap` 1, the 13 address bits and the data bits (both directions) travel least significant bit first. The direction bit stays first and the burst bit stays last.
- R6: With the burst flag set and select held low, every further data byte needs no control word and uses the previous address plus one, wrapping from 0x1FFF to 0x0000.
- R7: In a burst read, after each completed data byte `reg_rd` pulses for the next address, so that the following byte is ready in time.
- R8: With the burst flag clear and select held low, the byte after the data byte starts a new control word.
- R9: Raising the select before an access completes discards it: no `reg_wr` is issued, and the first byte after the select falls again is a control byte.
- R10: Raising the select ends a burst, and the next access uses the address from its own control word.
- R11: `reg_wr` and `reg_rd` are single-cycle pulses and never high together.
- R12: `spi_miso` is 0 while the select is high, during control bytes and during write data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpol | input | 1 | Static idle level of the serial clock |
| cpha | input | 1 | Static phase: 0 samples on the leading edge, 1 on the trailing edge |
| swap | input | 1 | Static bit order of address and data: 0 MSB first, 1 LSB first |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 13 | Register address, valid with either strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register read data, sampled in the `reg_rd` cycle |

## Verification
A control bit counter that slips by one position corrupts the address or swaps the direction and burst flags. This appears at the very next strobe, as a wrong address or a strobe of the wrong kind, within a cycle of the last control bit. A stale burst flag or frame state after a select release shows up as a write to an incremented address, or as a strobe that was never expected, in the first access after reselection. A misaligned transmit index shows up in the first read byte the host captures, as a rotated or bit-reversed value.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Frame position of the access engine: collecting control bits or moving data bytes.
  typedef enum logic {
    ST_CTRL = 1'b0,
    ST_DATA = 1'b1
  } acc_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_act,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_en,
  output logic              bit_ev,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              miso
);

  localparam int              CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sclk_prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_q;
  logic              miso_q, miso_d;
  logic              rise, fall, lead, trail, sample_ev, shift_ev;
  logic [CNT_W-1:0]  tx_idx;

  // Edge classification relative to the idle level.
  assign rise      = sclk_s & ~sclk_prev_q;
  assign fall      = ~sclk_s & sclk_prev_q;
  assign lead      = cpol ? fall : rise;
  assign trail     = cpol ? rise : fall;
  assign sample_ev = cs_act & (cpha ? trail : lead);
  assign shift_ev  = cs_act & (cpha ? lead : trail);

  // The same index serves both phases: in phase 0 the shift edge follows the
  // sample of bit k (counter already k+1), in phase 1 it precedes it (counter k).
  assign tx_idx    = LAST - cnt_q;
  assign rx_byte   = {rx_q[DATA_W-2:0], mosi_s};
  assign bit_ev    = sample_ev;
  assign byte_done = sample_ev & (cnt_q == LAST);
  assign miso      = miso_q;

  always_comb begin
    cnt_d  = cnt_q;
    miso_d = miso_q;
    if (!cs_act) begin
      cnt_d  = '0;
      miso_d = 1'b0;
    end else begin
      if (sample_ev) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (shift_ev)  miso_d = tx_en & tx_byte[tx_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      miso_q      <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      cnt_q       <= cnt_d;
      miso_q      <= miso_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_q <= '0;
    else if (sample_ev) rx_q <= rx_byte;
  end

endmodule

// File: rtl/spi_access_fsm.sv
module spi_access_fsm
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              swap,
  input  logic              bit_ev,
  input  logic              bit_val,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_en
);

  // Control word: direction, reserved filler, address, burst; whole bytes long.
  localparam int              CTRL_BYTES = (ADDR_W + 2 + DATA_W - 1) / DATA_W;
  localparam int              CTRL_W     = CTRL_BYTES * DATA_W;
  localparam int              CI_W       = $clog2(CTRL_W);
  localparam logic [CI_W-1:0] CI_LAST    = CI_W'(CTRL_W - 1);
  localparam logic [CI_W-1:0] CI_A0      = CI_W'(CTRL_W - 1 - ADDR_W);

  acc_state_e        state_q, state_d;
  logic [CI_W-1:0]   cidx_q, cidx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rw_q, rw_d;
  logic              burst_q, burst_d;
  logic              inc_q, inc_d;
  logic              wr_q, wr_d;
  logic              rd_q, rd_d;
  logic [DATA_W-1:0] wdata_q, tx_q;
  logic              wdata_en;
  logic [DATA_W-1:0] rx_rev, rd_rev, rx_ord, rd_ord;

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign rx_rev[g] = rx_byte[DATA_W-1-g];
    assign rd_rev[g] = reg_rdata[DATA_W-1-g];
  end

  assign rx_ord = swap ? rx_rev : rx_byte;
  assign rd_ord = swap ? rd_rev : reg_rdata;

  always_comb begin
    state_d  = state_q;
    cidx_d   = cidx_q;
    addr_d   = addr_q;
    rw_d     = rw_q;
    burst_d  = burst_q;
    inc_d    = 1'b0;
    wr_d     = 1'b0;
    rd_d     = 1'b0;
    wdata_en = 1'b0;
    if (inc_q) addr_d = addr_q + 1'b1;
    if (!cs_act) begin
      state_d = ST_CTRL;
      cidx_d  = '0;
      burst_d = 1'b0;
    end else if (state_q == ST_CTRL) begin
      if (bit_ev) begin
        if (cidx_q == CI_LAST) begin
          cidx_d  = '0;
          burst_d = bit_val;
          state_d = ST_DATA;
          rd_d    = rw_q;
        end else begin
          cidx_d = cidx_q + 1'b1;
          if (cidx_q == '0) begin
            rw_d = bit_val;
          end else if (cidx_q >= CI_A0) begin
            addr_d = swap ? {bit_val, addr_q[ADDR_W-1:1]}
                          : {addr_q[ADDR_W-2:0], bit_val};
          end
        end
      end
    end else if (byte_done) begin
      if (rw_q) begin
        if (burst_q) begin
          addr_d = addr_q + 1'b1;
          rd_d   = 1'b1;
        end
      end else begin
        wr_d     = 1'b1;
        wdata_en = 1'b1;
        inc_d    = burst_q;
      end
      if (!burst_q) state_d = ST_CTRL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CTRL;
      cidx_q  <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      burst_q <= 1'b0;
      inc_q   <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cidx_q  <= cidx_d;
      addr_q  <= addr_d;
      rw_q    <= rw_d;
      burst_q <= burst_d;
      inc_q   <= inc_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= rx_ord;
  end

  // The read byte is captured in the strobe cycle, ordered for the wire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tx_q <= '0;
    else if (rd_q) tx_q <= rd_ord;
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;
  assign tx_byte   = tx_q;
  assign tx_en     = (state_q == ST_DATA) & rw_q;

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              swap,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);

  logic              rst_n_i;
  logic [2:0]        pins_s;
  logic              cs_act;
  logic              bit_ev, byte_done, tx_en;
  logic [DATA_W-1:0] rx_byte, tx_byte;

  spi_pin_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_i)
  );

  // All three host pins share one synchronizer depth so edges and data stay aligned.
  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     (pins_s)
  );

  assign cs_act = ~pins_s[2];

  spi_bit_engine #(.DATA_W(DATA_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .sclk_s    (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .cs_act    (cs_act),
    .cpol      (cpol),
    .cpha      (cpha),
    .tx_byte   (tx_byte),
    .tx_en     (tx_en),
    .bit_ev    (bit_ev),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cs_act    (cs_act),
    .swap      (swap),
    .bit_ev    (bit_ev),
    .bit_val   (pins_s[0]),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .tx_byte   (tx_byte),
    .tx_en     (tx_en)
  );

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              spi_miso
);

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  a_r11_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  a_r11_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  a_r9_no_wr_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !reg_wr);

  a_r12_miso_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);

  a_r6_addr_step_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_addr == $past(reg_addr)) ||
               (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_act   (cs_act),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .spi_miso (spi_miso)
);

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;

  localparam int AW   = 13;
  localparam int DW   = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, swap = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic          miso, reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit            rd;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } ev_t;
  ev_t expq[$];

  always #2.5 clk = ~clk;

  spi_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .swap(swap),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [DW-1:0] rmodel(input logic [AW-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign reg_rdata = rmodel(reg_addr);

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [AW-1:0] rev13(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Reference: every strobe must match the oldest expected register event.
  logic prev_wr = 1'b0, prev_rd = 1'b0;
  always @(negedge clk) begin : monitor
    ev_t e;
    if (rst_n) begin
      if (reg_wr && reg_rd) check(1'b0, "R11", "both strobes high", 1, 0);
      if ((reg_wr && prev_wr) || (reg_rd && prev_rd))
        check(1'b0, "R11", "strobe longer than one cycle", 2, 1);
      if (reg_wr || reg_rd) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected strobe", int'({reg_rd, reg_addr}), 0);
        end else begin
          e = expq.pop_front();
          check(e.rd == reg_rd && e.a == reg_addr && (e.rd || e.d == reg_wdata),
                e.tag, "strobe {rd,addr,wdata}",
                int'({reg_rd, reg_addr, reg_wdata}), int'({e.rd, e.a, e.d}));
        end
      end
      prev_wr = reg_wr;
      prev_rd = reg_rd;
    end
  end

  task automatic half_p();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic push_ev(input bit rd, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string tag);
    ev_t e;
    e.rd = rd; e.a = a; e.d = d; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic xfer_bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      if (!cpha) begin
        mosi = b[i]; half_p(); r[i] = miso; sclk = ~cpol; half_p(); sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = b[i]; half_p(); r[i] = miso; sclk = cpol; half_p();
      end
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0; half_p();
  endtask

  task automatic cs_off();
    half_p(); cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic send_ctrl(input bit rw, input bit rsv, input logic [AW-1:0] a,
                           input bit burst, input string tag);
    logic [15:0] w;
    logic [7:0]  r;
    w = {rw, rsv, (swap ? rev13(a) : a), burst};
    if (rw) push_ev(1'b1, a, '0, tag);
    xfer_bits(w[15:8], 8, r);
    check(r == 8'h00, "R12", "MISO during control byte", r, 0);
    xfer_bits(w[7:0], 8, r);
    check(r == 8'h00, "R12", "MISO during control byte", r, 0);
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    logic [7:0] r;
    push_ev(1'b0, a, d, tag);
    xfer_bits(swap ? rev8(d) : d, 8, r);
    check(r == 8'h00, "R12", "MISO during write data", r, 0);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, input bit burst, input string tag);
    logic [7:0] r, x;
    if (burst) push_ev(1'b1, AW'(a + 1), '0, "R7");
    x = swap ? rev8(rmodel(a)) : rmodel(a);
    xfer_bits(8'hC3, 8, r);
    check(r == x, tag, "MISO read byte", r, x);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "run did not finish", 0, 1);
    finish_up();
  end

  initial begin : stim
    logic [7:0] dummy;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(reg_wr == 1'b0, "R1", "reg_wr after reset", reg_wr, 0);
    check(reg_rd == 1'b0, "R1", "reg_rd after reset", reg_rd, 0);
    check(miso == 1'b0, "R1", "miso after reset", miso, 0);
    check(reg_addr == '0, "R1", "reg_addr after reset", reg_addr, 0);

    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a1, a2, a3, a4, a5, a6, a7;
      cpol = k[2]; cpha = k[1]; swap = k[0];
      sclk = cpol;
      repeat (4 * HALF) @(negedge clk);
      a1 = AW'(13'h0100 + k * 37);
      a2 = AW'(13'h1A40 + k * 11);
      a3 = AW'(13'h0123 + k * 5);
      a4 = AW'(13'h0777 + k);
      a5 = AW'(13'h0555 + k * 3);
      a6 = AW'(13'h0F00 + k * 7);
      a7 = AW'(13'h0040 + k * 9);

      // R2 write with the ignored bit set, then R8 a CS-held read with new control.
      cs_on();
      send_ctrl(1'b0, 1'b1, a1, 1'b0, "R2");
      wr_byte(a1, 8'hB4 ^ 8'(k), swap ? "R5" : "R2");
      send_ctrl(1'b1, 1'b0, a2, 1'b0, "R8");
      rd_byte(a2, 1'b0, swap ? "R5" : "R3");
      cs_off();

      // R6 burst write across the top of the address space.
      cs_on();
      send_ctrl(1'b0, 1'b0, 13'h1FFE, 1'b1, "R6");
      wr_byte(13'h1FFE, 8'h11, "R6");
      wr_byte(13'h1FFF, 8'h22, "R6");
      wr_byte(13'h0000, 8'h33, "R6");
      cs_off();

      // R7 burst read with prefetch of the next address.
      cs_on();
      send_ctrl(1'b1, 1'b0, a3, 1'b1, "R7");
      rd_byte(a3, 1'b1, "R7");
      rd_byte(AW'(a3 + 1), 1'b1, "R7");
      rd_byte(AW'(a3 + 2), 1'b1, "R7");
      cs_off();

      // R9 aborts: inside the control word, then inside the data byte.
      cs_on();
      xfer_bits(8'h0F, 8, dummy);
      cs_off();
      cs_on();
      send_ctrl(1'b0, 1'b0, a4, 1'b0, "R9");
      xfer_bits(8'hE7, 5, dummy);
      cs_off();
      cs_on();
      send_ctrl(1'b0, 1'b0, a5, 1'b0, "R9");
      wr_byte(a5, 8'h5C, "R9");
      cs_off();

      // R10 burst closed by select release; next access uses its own address.
      cs_on();
      send_ctrl(1'b0, 1'b0, a6, 1'b1, "R10");
      wr_byte(a6, 8'h9A, "R10");
      cs_off();
      cs_on();
      send_ctrl(1'b0, 1'b0, a7, 1'b0, "R10");
      wr_byte(a7, 8'h6D, "R10");
      cs_off();

      // R4 every expected strobe of this clock mode has been seen.
      check(expq.size() == 0, "R4", "pending strobes after mode", expq.size(), 0);
      check(miso == 1'b0, "R12", "MISO while deselected", miso, 0);
    end
    finish_up();
  end

endmodule